// File: doc/BRIEF.md
# ARX Keystream Block Core

This core turns a fully assembled 512-bit cipher state into one 64-byte keystream block. The caller builds the state beforehand from the constants, key, block counter and nonce. The core treats the state as sixteen 32-bit words arranged in four rows of four. Each row is processed as four parallel lanes that use add, rotate and XOR operations. The core alternates column layers and diagonal layers until the requested round count has been used up. It then adds the original input back into the result, one word at a time.

The core applies one quarterround layer per clock cycle, using all four lanes together. A diagonal layer uses the same lane hardware as a column layer. Before a diagonal layer, the three lower rows are shifted left by one, two and three word positions. After the layer they are shifted back to their original places. A job is launched with a single `start` pulse. `busy` stays high while the job runs, and `done` pulses for one cycle when the result is ready.

Top module: `arx_block_core`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `state_out` is all zeros.
- R2: A `start` pulse seen while `busy` is 0 captures `state_in` and `rounds`. `busy` reads 1 in the following cycle.
- R3: State word i occupies `state_in[32*i +: 32]` and `state_out[32*i +: 32]`, so byte k is at bit 8k (little-endian). Row a is words 0..3, b is 4..7, c is 8..11 and d is 12..15.
- R4: Each lane computes, in this order: a+=b, d^=a, d rotated left 16; c+=d, b^=c, b rotated left 12; a+=b, d^=a, d rotated left 8; c+=d, b^=c, b rotated left 7. Sums are modulo 2^32 and rotations are circular.
- R5: In a column layer, lane i uses word i of every row. In a diagonal layer, lane i uses a[i], b[(i+1)%4], c[(i+2)%4] and d[(i+3)%4].
- R6: A double round is one column layer followed by one diagonal layer. With a count n, the core runs 1 double round if n <= 2, and otherwise ceil(n/2) double rounds.
- R7: A round count of 0, 1 or 2 gives exactly the same output as a count of 2.
- R8: The output is the working state after the last double round plus the captured input, added word by word modulo 2^32. A 20-round job must reproduce the published test block.
- R9: `done` rises exactly 2*P+1 cycles after the start edge, where P is the number of double rounds. `busy` stays 1 from the start edge until then.
- R10: `done` is high for one cycle only. `state_out` keeps its value until the next job finishes.
- R11: A `start` pulse while `busy` is 1 has no effect on the result or on the completion time of the running job.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch a job; sampled only while idle |
| rounds | input | CNT_W | Requested round count |
| state_in | input | 512 | Assembled input state, word i at bits 32i |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle result-ready pulse |
| state_out | output | 512 | Keystream block, held until the next completion |

## Verification
Two things can happen in the same cycle: a job finishes with its `done` pulse, and the next job is launched. The testbench raises `start` with a new state in exactly the cycle where `done` is high. It then checks that the finished block was presented intact in that cycle. It also checks that the block stays on `state_out` while the new job runs, and that the new job still produces the right result with the right latency. A second case places a `start` pulse in the middle of a running job and checks that the job's result and timing are unchanged.

// File: rtl/arx_block_core.sv
module arx_block_core #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] rounds,
  input  logic [511:0]     state_in,
  output logic             busy,
  output logic             done,
  output logic [511:0]     state_out
);
  localparam int WORDS = 16;
  localparam int LANES = 4;

  logic [WORDS-1:0][31:0] work_q, save_q, out_q, nxt;
  logic [CNT_W-1:0]       remain_q;
  logic                   rnd_q, feed_q, diag_q, done_q;

  function automatic logic [31:0] rotl(input logic [31:0] x, input int n);
    return (x << n) | (x >> (32 - n));
  endfunction

  function automatic logic [127:0] qround(input logic [31:0] a0, b0, c0, d0);
    logic [31:0] a, b, c, d;
    a = a0; b = b0; c = c0; d = d0;
    a = a + b; d = rotl(d ^ a, 16);
    c = c + d; b = rotl(b ^ c, 12);
    a = a + b; d = rotl(d ^ a, 8);
    c = c + d; b = rotl(b ^ c, 7);
    return {d, c, b, a};
  endfunction

  always_comb begin
    nxt = work_q;
    for (int i = 0; i < LANES; i++) begin
      int ib, ic, id;
      logic [127:0] r;
      ib = 4  + (diag_q ? ((i + 1) % LANES) : i);
      ic = 8  + (diag_q ? ((i + 2) % LANES) : i);
      id = 12 + (diag_q ? ((i + 3) % LANES) : i);
      r  = qround(work_q[i], work_q[ib], work_q[ic], work_q[id]);
      nxt[i]  = r[31:0];
      nxt[ib] = r[63:32];
      nxt[ic] = r[95:64];
      nxt[id] = r[127:96];
    end
  end

  assign busy      = rnd_q | feed_q;
  assign done      = done_q;
  assign state_out = out_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      work_q   <= '0;
      save_q   <= '0;
      out_q    <= '0;
      remain_q <= '0;
      rnd_q    <= 1'b0;
      feed_q   <= 1'b0;
      diag_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start && !busy) begin
        work_q   <= state_in;
        save_q   <= state_in;
        remain_q <= rounds;
        diag_q   <= 1'b0;
        rnd_q    <= 1'b1;
      end
      if (rnd_q) begin
        work_q <= nxt;
        diag_q <= ~diag_q;
        if (diag_q) begin
          if (remain_q > CNT_W'(2)) remain_q <= remain_q - CNT_W'(2);
          else begin
            rnd_q  <= 1'b0;
            feed_q <= 1'b1;
          end
        end
      end
      if (feed_q) begin
        for (int w = 0; w < WORDS; w++) out_q[w] <= work_q[w] + save_q[w];
        feed_q <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    $past(!rst_n) |-> (!busy && !done));
  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  assert_continue_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rnd_q && diag_q && remain_q > CNT_W'(2)) |=> (rnd_q && !done));
  assert_done_after_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy));
  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_out_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(state_out));
  assert_busy_start_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy) |=> $stable(save_q));
endmodule

// File: tb/arx_block_core_tb.sv
module arx_block_core_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [7:0]   rounds = '0;
  logic [511:0] state_in = '0;
  logic         busy, done;
  logic [511:0] state_out;
  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #4 clk = ~clk;

  arx_block_core #(.CNT_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .rounds(rounds),
    .state_in(state_in), .busy(busy), .done(done), .state_out(state_out)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual=%0d cycles expected<=100000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  function automatic logic [31:0] rl(input logic [31:0] x, input int n);
    return (x << n) | (x >> (32 - n));
  endfunction

  function automatic int passes(input int n);
    return (n <= 2) ? 1 : (n + 1) / 2;
  endfunction

  function automatic logic [511:0] model(input logic [511:0] s, input int n);
    logic [31:0] x [16];
    logic [511:0] r;
    for (int w = 0; w < 16; w++) x[w] = s[32*w +: 32];
    for (int p = 0; p < passes(n); p++) begin
      for (int k = 0; k < 8; k++) begin
        int j, ia, ib, ic, id;
        j  = k % 4;
        ia = j;
        ib = (k < 4) ? 4 + j  : 4 + ((j + 1) % 4);
        ic = (k < 4) ? 8 + j  : 8 + ((j + 2) % 4);
        id = (k < 4) ? 12 + j : 12 + ((j + 3) % 4);
        x[ia] = x[ia] + x[ib]; x[id] = rl(x[id] ^ x[ia], 16);
        x[ic] = x[ic] + x[id]; x[ib] = rl(x[ib] ^ x[ic], 12);
        x[ia] = x[ia] + x[ib]; x[id] = rl(x[id] ^ x[ia], 8);
        x[ic] = x[ic] + x[id]; x[ib] = rl(x[ib] ^ x[ic], 7);
      end
    end
    for (int w = 0; w < 16; w++) r[32*w +: 32] = x[w] + s[32*w +: 32];
    return r;
  endfunction

  task automatic check(input string req, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic launch(input logic [511:0] s, input int n);
    state_in = s; rounds = 8'(n); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic finish(input string req, input logic [511:0] exp, input int n, input int cnt0);
    int cnt = cnt0;
    check({req, " R2 busy after start"}, 512'(busy), 512'(1));
    while (!done && cnt < 1000) begin
      @(negedge clk);
      cnt++;
      if (!done && !busy) begin
        check({req, " R9 busy during job"}, 512'(busy), 512'(1));
        cnt = 1000;
      end
    end
    check({req, " R9 latency"}, 512'(cnt), 512'(2 * passes(n) + 1));
    check({req, " R8 result"}, state_out, exp);
  endtask

  function automatic logic [511:0] pattern(input logic [31:0] seed);
    logic [511:0] r;
    for (int w = 0; w < 16; w++) r[32*w +: 32] = seed * (w + 3) ^ 32'h9e3779b9 * w;
    return r;
  endfunction

  task automatic t_reset;
    check("R1 busy", 512'(busy), 512'(0));
    check("R1 done", 512'(done), 512'(0));
    check("R1 out", state_out, '0);
  endtask

  task automatic t_kat;
    logic [511:0] s, e;
    s = {32'h00000000, 32'h4a000000, 32'h09000000, 32'h00000001,
         32'h1f1e1d1c, 32'h1b1a1918, 32'h17161514, 32'h13121110,
         32'h0f0e0d0c, 32'h0b0a0908, 32'h07060504, 32'h03020100,
         32'h6b206574, 32'h79622d32, 32'h3320646e, 32'h61707865};
    e = {32'h4e3c50a2, 32'he883d0cb, 32'hb94e16de, 32'hd19c12b5,
         32'ha2028bd9, 32'h05d7c214, 32'h09aa9f07, 32'h466482d2,
         32'h4e6cd4c3, 32'h9aaa2204, 32'h0368c033, 32'hc7f4d1c7,
         32'hc47120a3, 32'h1fdd0f50, 32'h15593bd1, 32'he4e7f110};
    launch(s, 20);
    finish("R3 R4 R5 known answer 20 rounds", e, 20, 0);
    @(negedge clk);
    check("R10 done single", 512'(done), 512'(0));
    check("R10 out held", state_out, e);
  endtask

  task automatic t_model(input int n, input logic [31:0] seed);
    logic [511:0] s = pattern(seed);
    launch(s, n);
    finish($sformatf("R6 model %0d rounds", n), model(s, n), n, 0);
    @(negedge clk);
  endtask

  task automatic t_low_counts;
    logic [511:0] s = pattern(32'h13579bdf);
    logic [511:0] ref2 = model(s, 2);
    for (int n = 0; n <= 2; n++) begin
      launch(s, n);
      finish($sformatf("R7 count %0d", n), ref2, n, 0);
      @(negedge clk);
    end
  endtask

  task automatic t_carry;
    logic [511:0] s = '1;
    launch(s, 8);
    finish("R8 feedforward carry", model(s, 8), 8, 0);
    @(negedge clk);
  endtask

  task automatic t_back_to_back;
    logic [511:0] sa = pattern(32'hcafef00d);
    logic [511:0] sb = pattern(32'h0badc0de);
    logic [511:0] ea = model(sa, 12);
    launch(sa, 12);
    finish("R10 first of pair", ea, 12, 0);
    launch(sb, 8);
    check("R10 done drop at relaunch", 512'(done), 512'(0));
    check("R10 out held during next job", state_out, ea);
    finish("R2 relaunch in done cycle", model(sb, 8), 8, 0);
    @(negedge clk);
  endtask

  task automatic t_busy_start;
    logic [511:0] sa = pattern(32'h2468ace0);
    launch(sa, 12);
    repeat (4) @(negedge clk);
    state_in = pattern(32'h11111111); rounds = 8'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    finish("R11 start while busy", model(sa, 12), 12, 5);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_kat();
    t_model(8, 32'h01234567);
    t_model(12, 32'h89abcdef);
    t_model(5, 32'h55aa55aa);
    t_model(255, 32'h76543210);
    t_low_counts();
    t_carry();
    t_back_to_back();
    t_busy_start();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule